// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 data cache lookup

This block is the read lookup path of a first-level data cache that overlaps set selection with address translation. The cache holds 64 sets of 8 ways with 64-byte lines, 32 KB in all. Line offset and set index together occupy exactly the 12 bits of the page offset, so the set can be chosen before the page number has been translated. When a request is accepted, the block captures the tag, valid bit and addressed word of all eight ways of that set. It then waits for the physical page number, which arrives later with its own strobe. A translation-miss flag from the TLB holds the compare back for as long as it is high.

The stored tag is the full 40-bit physical page number. A match returns the captured word at once. A miss raises a refill request carrying the line-aligned physical address. The returned 64-byte line is installed in the set, with an empty way preferred and the least recently used way taken otherwise. The requested word is then returned from that line. Replacement is true LRU, kept as a per-way age rank inside each set. Only one lookup is in flight at a time.

Top module: `vipt_dcache`

## Requirements
- R1: While reset is asserted and in the cycle after it, `req_ready` is 1 and `resp_valid` and `refill_req` are 0. Reset invalidates every line, so the first lookup of any address after reset is a miss.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_pgoff[11:6]` selects the set and `req_pgoff[5:2]` selects the 32-bit word in the line. `req_ready` stays 0 from the cycle after acceptance until the response.
- R3: After acceptance, no response and no refill request appear until a clock edge at which `ppn_valid` is 1 and `tlb_miss` is 0. The set contents captured at acceptance are kept through any such wait.
- R4: While `tlb_miss` is 1, the compare does not happen even when `ppn_valid` is 1.
- R5: If a valid way of the set holds a tag equal to `ppn` at the compare edge, the next cycle shows `resp_valid`=1, `resp_hit`=1 and `resp_data` equal to the addressed word.
- R6: On a miss, `refill_req` rises in the cycle after the compare edge with `refill_addr` = {ppn, set, 6'b0}. Both stay unchanged until an edge with `refill_valid`=1.
- R7: `refill_line` carries word k in bits [32k+31:32k]. In the cycle after the edge that takes it, `refill_req` is 0, `resp_valid`=1, `resp_hit`=0, and `resp_data` is the addressed word of the line. The line then hits on later lookups.
- R8: The fill goes to the lowest-numbered invalid way of the set. If none is invalid, it goes to the least recently used way. Both a hit and an install make the way the most recently used.
- R9: Sets are independent: the same page number in a different set is a distinct line.
- R10: `resp_valid` is a one-cycle pulse and is never 1 together with `refill_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_pgoff | input | 12 | Page-offset bits of the virtual address |
| req_ready | output | 1 | Block can accept a request |
| ppn_valid | input | 1 | Translated page number is present |
| ppn | input | 40 | Translated physical page number |
| tlb_miss | input | 1 | Translation not yet available; holds the compare |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | 1 for a hit, 0 for a response after refill |
| resp_data | output | 32 | Addressed word |
| refill_req | output | 1 | Line fetch request |
| refill_addr | output | 52 | Line-aligned physical address of the missing line |
| refill_valid | input | 1 | Refill line present |
| refill_line | input | 512 | Refill line data |

## Verification
The bound checker watches the handshake sequence on every cycle. It checks that no result or refill leaves the block while translation is missing or stalled, that a compare ends in either a hit response or a refill request, that the refill address stays stable and aligned while it waits, and that responses are single pulses separate from refill requests. Only the bench scenarios can show which data comes back, whether the right way was evicted once a set is full, and that reset really empties the cache. The bench shows these through sequences of hits and misses whose outcomes depend on the LRU order.

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int PPN_W  = 40,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 6,
  parameter int WAYS   = 8,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [SET_W+OFF_W-1:0]        req_pgoff,
  output logic                          req_ready,
  input  logic                          ppn_valid,
  input  logic [PPN_W-1:0]              ppn,
  input  logic                          tlb_miss,
  output logic                          resp_valid,
  output logic                          resp_hit,
  output logic [WORD_W-1:0]             resp_data,
  output logic                          refill_req,
  output logic [PPN_W+SET_W+OFF_W-1:0]  refill_addr,
  input  logic                          refill_valid,
  input  logic [(8<<OFF_W)-1:0]         refill_line
);

  localparam int LINE_BITS = 8 << OFF_W;
  localparam int WPL       = LINE_BITS / WORD_W;
  localparam int WSEL_W    = $clog2(WPL);
  localparam int BSEL_W    = OFF_W - WSEL_W;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int ENT       = (1 << SET_W) * WAYS;
  localparam int ENT_W     = SET_W + WAY_W;

  typedef enum logic [1:0] {IDLE, CMP, FILL} st_t;
  st_t state;

  logic [LINE_BITS-1:0] data_q [ENT];
  logic [PPN_W-1:0]     tag_q  [ENT];
  logic [WAY_W-1:0]     age_q  [ENT];
  logic [ENT-1:0]       vld_q;

  logic [SET_W-1:0]  set_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [PPN_W-1:0]  way_tag_q  [WAYS];
  logic [WORD_W-1:0] way_word_q [WAYS];
  logic [WAYS-1:0]   way_vld_q;

  logic [SET_W-1:0]  req_set;
  logic [WSEL_W-1:0] req_wsel;
  logic              unused_bsel;
  logic              go, hit_any, any_inv, touch_en, fill_go;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way, vic_inv, vic_lru, victim, touch_way, t_age;

  assign req_set     = req_pgoff[SET_W+OFF_W-1:OFF_W];
  assign req_wsel    = req_pgoff[OFF_W-1:BSEL_W];
  assign unused_bsel = ^req_pgoff[BSEL_W-1:0];
  assign req_ready   = (state == IDLE);
  assign go          = (state == CMP) && ppn_valid && !tlb_miss;
  assign fill_go     = (state == FILL) && refill_valid;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = way_vld_q[w] && (way_tag_q[w] == ppn);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit_any = |hit_vec;

  always_comb begin
    vic_inv = '0;
    vic_lru = '0;
    any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[{set_q, WAY_W'(w)}]) begin
        vic_inv = WAY_W'(w);
        any_inv = 1'b1;
      end
      if (age_q[{set_q, WAY_W'(w)}] == WAY_W'(WAYS - 1)) vic_lru = WAY_W'(w);
    end
  end
  assign victim = any_inv ? vic_inv : vic_lru;

  assign touch_en  = (go && hit_any) || fill_go;
  assign touch_way = (state == FILL) ? victim : hit_way;
  assign t_age     = age_q[{set_q, touch_way}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT; e++) begin
        vld_q[e] <= 1'b0;
        age_q[e] <= WAY_W'(e);
      end
    end else begin
      if (fill_go) vld_q[{set_q, victim}] <= 1'b1;
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way)
            age_q[{set_q, WAY_W'(w)}] <= '0;
          else if (age_q[{set_q, WAY_W'(w)}] < t_age)
            age_q[{set_q, WAY_W'(w)}] <= age_q[{set_q, WAY_W'(w)}] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      data_q[{set_q, victim}] <= refill_line;
      tag_q[{set_q, victim}]  <= ppn_q;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) begin
      set_q  <= req_set;
      wsel_q <= req_wsel;
      for (int w = 0; w < WAYS; w++) begin
        way_tag_q[w]  <= tag_q[{req_set, WAY_W'(w)}];
        way_vld_q[w]  <= vld_q[{req_set, WAY_W'(w)}];
        way_word_q[w] <= data_q[{req_set, WAY_W'(w)}][req_wsel*WORD_W +: WORD_W];
      end
    end
    if (go && !hit_any) ppn_q <= ppn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_data   <= '0;
      refill_req  <= 1'b0;
      refill_addr <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) state <= CMP;
        CMP: if (go) begin
          if (hit_any) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_data  <= way_word_q[hit_way];
            state      <= IDLE;
          end else begin
            refill_req  <= 1'b1;
            refill_addr <= {ppn, set_q, {OFF_W{1'b0}}};
            state       <= FILL;
          end
        end
        FILL: if (refill_valid) begin
          refill_req <= 1'b0;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_data  <= refill_line[wsel_q*WORD_W +: WORD_W];
          state      <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int PA_W  = 52,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            ppn_valid,
  input logic            tlb_miss,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic            refill_req,
  input logic            refill_valid,
  input logic [PA_W-1:0] refill_addr
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !resp_valid && !refill_req));

  a_r2_resp_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !refill_req && (tlb_miss || !ppn_valid)) |=> (!resp_valid && !refill_req));

  a_r5_compare_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !refill_req && ppn_valid && !tlb_miss) |=>
      ((resp_valid && resp_hit) || (refill_req && !resp_valid)));

  a_r6_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));

  a_r6_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> (refill_addr[OFF_W-1:0] == '0));

  a_r7_fill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && refill_valid) |=> (resp_valid && !resp_hit && !refill_req));

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && refill_req));

endmodule

bind vipt_dcache vipt_dcache_chk #(.PA_W(PPN_W + SET_W + OFF_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ppn_valid(ppn_valid),
  .tlb_miss(tlb_miss), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .refill_req(refill_req), .refill_valid(refill_valid), .refill_addr(refill_addr)
);

// File: tb/test_vipt_dcache.sv
`timescale 1ns/1ps
module test_vipt_dcache;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [11:0]  req_pgoff = '0;
  logic         req_ready;
  logic         ppn_valid = 1'b0;
  logic [39:0]  ppn = '0;
  logic         tlb_miss = 1'b0;
  logic         resp_valid, resp_hit;
  logic [31:0]  resp_data;
  logic         refill_req;
  logic [51:0]  refill_addr;
  logic         refill_valid = 1'b0;
  logic [511:0] refill_line = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vipt_dcache i_vipt_dcache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pgoff(req_pgoff),
    .req_ready(req_ready), .ppn_valid(ppn_valid), .ppn(ppn), .tlb_miss(tlb_miss),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .refill_req(refill_req), .refill_addr(refill_addr),
    .refill_valid(refill_valid), .refill_line(refill_line)
  );

  typedef struct packed {
    logic [39:0] pn;
    logic [5:0]  set;
    logic [3:0]  wd;
    logic        hit;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{40'd1, 6'd5, 4'd0,  1'b0},
    '{40'd1, 6'd5, 4'd3,  1'b1},
    '{40'd2, 6'd5, 4'd0,  1'b0},
    '{40'd3, 6'd5, 4'd1,  1'b0},
    '{40'd4, 6'd5, 4'd2,  1'b0},
    '{40'd5, 6'd5, 4'd0,  1'b0},
    '{40'd6, 6'd5, 4'd0,  1'b0},
    '{40'd7, 6'd5, 4'd0,  1'b0},
    '{40'd8, 6'd5, 4'd15, 1'b0},
    '{40'd1, 6'd5, 4'd7,  1'b1},
    '{40'd9, 6'd5, 4'd0,  1'b0},
    '{40'd2, 6'd5, 4'd0,  1'b0},
    '{40'd1, 6'd5, 4'd2,  1'b1},
    '{40'd3, 6'd5, 4'd0,  1'b0},
    '{40'd1, 6'd6, 4'd0,  1'b0},
    '{40'd9, 6'd5, 4'd4,  1'b1},
    '{40'hFF_FFFF_FFFF, 6'd63, 4'd15, 1'b0},
    '{40'hFF_FFFF_FFFF, 6'd63, 4'd9,  1'b1}
  };

  function automatic logic [31:0] gen_word(input logic [39:0] p, input logic [5:0] s, input logic [3:0] k);
    return {p[11:0], s, k, 10'h2A5};
  endfunction

  function automatic logic [511:0] gen_line(input logic [39:0] p, input logic [5:0] s);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = gen_word(p, s, 4'(k));
    return l;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [39:0] p, input logic [5:0] s, input logic [3:0] wd,
                        input int ppn_wait, input int tlb_wait, input int fill_wait,
                        input bit exp_hit, input string rq);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_pgoff = {s, wd, 2'b01};
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "busy after accept", 64'(req_ready), 64'd0);
    for (int i = 0; i < ppn_wait; i++) begin
      @(negedge clk);
      chk(!resp_valid && !refill_req, "R3", "quiet without translation",
          64'({resp_valid, refill_req}), 64'd0);
    end
    ppn_valid = 1'b1;
    ppn = p;
    tlb_miss = (tlb_wait > 0);
    for (int i = 0; i < tlb_wait; i++) begin
      @(negedge clk);
      chk(!resp_valid && !refill_req, "R4", "quiet during tlb miss",
          64'({resp_valid, refill_req}), 64'd0);
    end
    tlb_miss = 1'b0;
    @(negedge clk);
    ppn_valid = 1'b0;
    if (refill_req) begin
      chk(refill_addr == {p, s, 6'd0}, "R6", "refill address", 64'(refill_addr), 64'({p, s, 6'd0}));
      for (int i = 0; i < fill_wait; i++) begin
        @(negedge clk);
        chk(refill_req && !resp_valid, "R6", "request held", 64'({refill_req, resp_valid}), 64'b10);
      end
      refill_valid = 1'b1;
      refill_line = gen_line(p, s);
      @(negedge clk);
      refill_valid = 1'b0;
      chk(!refill_req, "R7", "request dropped after fill", 64'(refill_req), 64'd0);
    end
    chk(resp_valid == 1'b1, rq, "response present", 64'(resp_valid), 64'd1);
    chk(resp_hit == exp_hit, rq, "hit flag", 64'(resp_hit), 64'(exp_hit));
    chk(resp_data == gen_word(p, s, wd), rq, "read word", 64'(resp_data), 64'(gen_word(p, s, wd)));
    @(negedge clk);
    chk(!resp_valid, "R10", "single pulse", 64'(resp_valid), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !refill_req, "R1", "outputs in reset",
        64'({req_ready, resp_valid, refill_req}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !refill_req, "R1", "outputs after reset",
        64'({req_ready, resp_valid, refill_req}), 64'b100);

    // R5 R7 R8 R9: table walk, set 5 filled then evicted in LRU order
    for (int i = 0; i < 18; i++)
      lookup(VEC[i].pn, VEC[i].set, VEC[i].wd, i % 3, (i % 2) * 2, i % 4, VEC[i].hit,
             VEC[i].hit ? "R5" : "R8");

    // R4: long tlb stall on a resident line
    lookup(40'd9, 6'd5, 4'd11, 0, 6, 0, 1'b1, "R4");
    // R3: late translation
    lookup(40'd2, 6'd5, 4'd8, 7, 0, 0, 1'b1, "R3");
    // R9: same page number, other set
    lookup(40'd9, 6'd7, 4'd1, 0, 0, 2, 1'b0, "R9");
    lookup(40'd9, 6'd7, 4'd1, 1, 0, 0, 1'b1, "R9");
    // R6: long refill wait
    lookup(40'h12_3456_789A, 6'd0, 4'd5, 0, 0, 9, 1'b0, "R6");
    // R7: installed line now hits
    lookup(40'h12_3456_789A, 6'd0, 4'd6, 0, 1, 0, 1'b1, "R7");

    // R1: reset empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !refill_req, "R1", "idle after second reset",
        64'({req_ready, resp_valid, refill_req}), 64'b100);
    lookup(40'd9, 6'd5, 4'd0, 0, 0, 0, 1'b0, "R1");
    lookup(40'd9, 6'd5, 4'd2, 0, 0, 0, 1'b1, "R7");

    finish_run();
  end

endmodule